// File: doc/BRIEF.md
# Timing Pin Waveform Generator

This block drives one output pin from one of several time-of-day domains. Each domain supplies an integer nanosecond count that wraps at one billion, and a strobe that is high in the cycle in which that count wraps. The pin is set up through a small group of static inputs: an action code, a sync code, a domain index, and two 30-bit nanosecond values called the low value and the high value.

The block has two waveform modes. In free-running mode the pin alternates between a low phase and a high phase. Each phase lasts for its programmed number of nanoseconds, measured as time elapsed on the selected domain. In pulse-per-second mode the pin gives one pulse in each second of the selected domain. The pulse starts at the first point after the wrap where the count reaches the low value, which now serves as a phase offset. It lasts for the high value. The idle action holds the pin low.

Top module: `ptp_pin_wavegen`

## Requirements
- R1: The action code decides whether the pin runs. Code 1 runs it. Code 0 (idle) and the reserved codes 2 and 3 hold `pin_o` low from the clock edge after the code is sampled.
- R2: Free-running mode is action 1 with any sync code other than 3. On entry the pin is low. Timing begins on the next cycle. The pin then stays low until `low_ns_i` nanoseconds of the selected domain have elapsed, and high until `high_ns_i` nanoseconds have elapsed, repeating without end. With a count step of 5 ns per cycle, L = low/5 and H = high/5, the pin sampled after the k-th edge following entry (k = 0 at the entry edge) is high exactly when k mod (L+H) >= L.
- R3: In free-running mode, elapsed time is taken modulo one billion. A wrap of the selected count therefore does not disturb the waveform.
- R4: A change of the action, sync or domain inputs restarts the generator. The pin is low after the next edge, and the waveform pattern of R2 restarts from k = 0.
- R5: Pulse-per-second mode is action 1 with sync code 3. On entry the pin stays low until the selected domain's wrap strobe has been seen. This holds even if the count passes the phase offset before that.
- R6: After a wrap, the pin goes high from the edge after the first cycle whose count is at least `low_ns_i`. It stays high for `high_ns_i` nanoseconds, then waits for the next wrap. Exactly one pulse is given per second. With a 5 ns step, the pin after an edge is high exactly when the count in the cycle before that edge lies in [low, low + high) within a second whose wrap has been seen.
- R7: If the count in the wrap cycle already meets the phase offset (for example, a phase of 0), the pulse starts at that same edge.
- R8: A `high_ns_i` value of 0 keeps the pin low after the next edge, in either mode.
- R9: A domain index of N_DOM or greater holds the pin low after the next edge.
- R10: While `rst_ni` is low, the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| action_i | input | 2 | 0 idle, 1 run, 2 and 3 reserved (held low) |
| sync_i | input | 2 | 3 selects pulse-per-second; other values select free-running |
| dom_sel_i | input | SEL_W (2) | Index of the time-of-day domain |
| low_ns_i | input | NS_W (30) | Low-phase length, or phase offset in pulse-per-second mode |
| high_ns_i | input | NS_W (30) | High-phase length, or pulse width |
| dom_ns_i | input | N_DOM*NS_W (90) | Packed nanosecond counts; domain d sits at bits d*NS_W and up |
| dom_sec_i | input | N_DOM (3) | Per-domain wrap strobe, high in the cycle the count wraps |
| pin_o | output | 1 | Generated waveform |

## Verification
In pulse-per-second mode, two events can fall in the same cycle: the seconds wrap, which arms the pulse, and the phase match, which starts it. The bench provokes this with a phase of 0, so the count in the wrap cycle already meets the offset. It checks that the pulse begins at that wrap edge rather than one cycle later. It also checks that the pulse lasts four cycles at a 20 ns width. A further case crosses a wrap in free-running mode, where the elapsed-time step must take the wrap into account, and the waveform phase is checked for continuity across it.

// File: rtl/ptp_wave_pkg.sv
package ptp_wave_pkg;
  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_CLOCK = 2'd1,
    ACT_RSV2  = 2'd2,
    ACT_RSV3  = 2'd3
  } pin_act_e;

  localparam logic [1:0] SYNC_PPS = 2'd3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_FREE = 2'd1,
    MODE_PPS  = 2'd2
  } pin_mode_e;

  typedef enum logic [1:0] {
    PPS_WAIT_SEC = 2'd0,
    PPS_ARMED    = 2'd1,
    PPS_PULSE    = 2'd2
  } pps_st_e;
endpackage

// File: rtl/ptp_wave_dom_sel.sv
module ptp_wave_dom_sel
  import ptp_wave_pkg::*;
#(
  parameter int N_DOM = 3,
  parameter int NS_W  = 30,
  parameter int SEL_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [N_DOM*NS_W-1:0]   ns_flat_i,
  input  logic [N_DOM-1:0]        sec_i,
  output logic                    ok_o,
  output logic [NS_W-1:0]         ns_o,
  output logic                    sec_o,
  output logic [NS_W:0]           step_o
);
  localparam logic [NS_W:0]  SEC_NS = (NS_W+1)'(NS_PER_SEC);
  localparam logic [SEL_W:0] DOM_LIM = (SEL_W+1)'(N_DOM);

  logic [NS_W-1:0] ns_arr [N_DOM];
  logic [NS_W-1:0] prev_q;

  for (genvar g = 0; g < N_DOM; g++) begin : g_unpack
    assign ns_arr[g] = ns_flat_i[g*NS_W +: NS_W];
  end

  always_comb begin
    ns_o  = '0;
    sec_o = 1'b0;
    for (int i = 0; i < N_DOM; i++) begin
      if (sel_i == SEL_W'(i)) begin
        ns_o  = ns_arr[i];
        sec_o = sec_i[i];
      end
    end
  end

  assign ok_o = ({1'b0, sel_i} < DOM_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= ns_o;
  end

  // elapsed ns since last cycle, modulo one second
  always_comb begin
    if (ns_o >= prev_q) step_o = {1'b0, ns_o} - {1'b0, prev_q};
    else                step_o = {1'b0, ns_o} + SEC_NS - {1'b0, prev_q};
  end
endmodule

// File: rtl/ptp_wave_free.sv
module ptp_wave_free #(
  parameter int NS_W = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [NS_W:0]   step_i,
  input  logic [NS_W-1:0] low_i,
  input  logic [NS_W-1:0] high_i,
  output logic            level_o
);
  logic            phase_q;
  logic [NS_W:0]   acc_q;
  logic [NS_W+1:0] acc_n;
  logic [NS_W+1:0] len;

  always_comb begin
    len   = {2'b00, (phase_q ? high_i : low_i)};
    acc_n = {1'b0, acc_q} + {1'b0, step_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      acc_q   <= '0;
    end else if (!run_i || restart_i || high_i == '0) begin
      phase_q <= 1'b0;
      acc_q   <= '0;
    end else if (acc_n >= len) begin
      phase_q <= !phase_q;
      acc_q   <= (NS_W+1)'(acc_n - len);
    end else begin
      acc_q   <= acc_n[NS_W:0];
    end
  end

  assign level_o = phase_q;
endmodule

// File: rtl/ptp_wave_pps.sv
module ptp_wave_pps
  import ptp_wave_pkg::*;
#(
  parameter int NS_W = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic            sec_i,
  input  logic [NS_W-1:0] ns_i,
  input  logic [NS_W:0]   step_i,
  input  logic [NS_W-1:0] phase_i,
  input  logic [NS_W-1:0] width_i,
  output logic            level_o
);
  pps_st_e         st_q;
  logic [NS_W:0]   acc_q;
  logic [NS_W+1:0] acc_n;
  logic            hit;
  logic            wide;

  assign acc_n = {1'b0, acc_q} + {1'b0, step_i};
  assign hit   = (ns_i >= phase_i);
  assign wide  = (width_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PPS_WAIT_SEC;
      acc_q <= '0;
    end else if (!run_i || restart_i) begin
      st_q  <= PPS_WAIT_SEC;
      acc_q <= '0;
    end else begin
      unique case (st_q)
        PPS_WAIT_SEC: begin
          acc_q <= '0;
          if (sec_i) st_q <= (hit && wide) ? PPS_PULSE : PPS_ARMED;
        end
        PPS_ARMED: begin
          acc_q <= '0;
          if (hit) st_q <= wide ? PPS_PULSE : PPS_WAIT_SEC;
        end
        PPS_PULSE: begin
          if (!wide || acc_n >= {2'b00, width_i}) begin
            st_q  <= PPS_WAIT_SEC;
            acc_q <= '0;
          end else begin
            acc_q <= acc_n[NS_W:0];
          end
        end
        default: begin
          st_q  <= PPS_WAIT_SEC;
          acc_q <= '0;
        end
      endcase
    end
  end

  assign level_o = (st_q == PPS_PULSE);
endmodule

// File: rtl/ptp_pin_wavegen.sv
module ptp_pin_wavegen
  import ptp_wave_pkg::*;
#(
  parameter int N_DOM = 3,
  parameter int NS_W  = 30,
  localparam int SEL_W = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            action_i,
  input  logic [1:0]            sync_i,
  input  logic [SEL_W-1:0]      dom_sel_i,
  input  logic [NS_W-1:0]       low_ns_i,
  input  logic [NS_W-1:0]       high_ns_i,
  input  logic [N_DOM*NS_W-1:0] dom_ns_i,
  input  logic [N_DOM-1:0]      dom_sec_i,
  output logic                  pin_o
);
  logic             sel_ok;
  logic [NS_W-1:0]  sel_ns;
  logic             sel_sec;
  logic [NS_W:0]    step_ns;

  logic [1:0]       act_q, sync_q;
  logic [SEL_W-1:0] dom_q;
  pin_mode_e        mode_q, mode_d;
  logic             restart;
  logic             free_lvl, pps_lvl;

  ptp_wave_dom_sel #(.N_DOM(N_DOM), .NS_W(NS_W), .SEL_W(SEL_W)) u_dom (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (dom_sel_i),
    .ns_flat_i (dom_ns_i),
    .sec_i     (dom_sec_i),
    .ok_o      (sel_ok),
    .ns_o      (sel_ns),
    .sec_o     (sel_sec),
    .step_o    (step_ns)
  );

  assign restart = (action_i != act_q) || (sync_i != sync_q) || (dom_sel_i != dom_q);

  always_comb begin
    mode_d = MODE_OFF;
    if (action_i == ACT_CLOCK && sel_ok)
      mode_d = (sync_i == SYNC_PPS) ? MODE_PPS : MODE_FREE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= ACT_IDLE;
      sync_q <= '0;
      dom_q  <= '0;
      mode_q <= MODE_OFF;
    end else begin
      act_q  <= action_i;
      sync_q <= sync_i;
      dom_q  <= dom_sel_i;
      mode_q <= mode_d;
    end
  end

  ptp_wave_free #(.NS_W(NS_W)) u_free (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (mode_d == MODE_FREE),
    .restart_i (restart),
    .step_i    (step_ns),
    .low_i     (low_ns_i),
    .high_i    (high_ns_i),
    .level_o   (free_lvl)
  );

  ptp_wave_pps #(.NS_W(NS_W)) u_pps (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (mode_d == MODE_PPS),
    .restart_i (restart),
    .sec_i     (sel_sec),
    .ns_i      (sel_ns),
    .step_i    (step_ns),
    .phase_i   (low_ns_i),
    .width_i   (high_ns_i),
    .level_o   (pps_lvl)
  );

  always_comb begin
    unique case (mode_q)
      MODE_FREE: pin_o = free_lvl;
      MODE_PPS:  pin_o = pps_lvl;
      default:   pin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptp_pin_wavegen_chk.sv
module ptp_pin_wavegen_chk
  import ptp_wave_pkg::*;
#(
  parameter int N_DOM = 3,
  parameter int NS_W  = 30,
  parameter int SEL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       action_i,
  input logic [1:0]       sync_i,
  input logic [SEL_W-1:0] dom_sel_i,
  input logic [NS_W-1:0]  low_ns_i,
  input logic [NS_W-1:0]  high_ns_i,
  input logic [NS_W-1:0]  sel_ns,
  input logic             pin_o
);
  localparam logic [SEL_W:0] DOM_LIM = (SEL_W+1)'(N_DOM);

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (action_i != ACT_CLOCK) |=> !pin_o);

  p_restart_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({action_i, sync_i, dom_sel_i} != $past({action_i, sync_i, dom_sel_i})) |=> !pin_o);

  p_pps_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pin_o) && $past(sync_i) == SYNC_PPS) |-> ($past(sel_ns) >= $past(low_ns_i)));

  p_zero_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (high_ns_i == '0) |=> !pin_o);

  p_bad_dom_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, dom_sel_i} >= DOM_LIM) |=> !pin_o);

  always_comb begin
    if (!rst_ni) p_reset_low_r10: assert (!pin_o);
  end
endmodule

bind ptp_pin_wavegen ptp_pin_wavegen_chk #(.N_DOM(N_DOM), .NS_W(NS_W), .SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .action_i  (action_i),
  .sync_i    (sync_i),
  .dom_sel_i (dom_sel_i),
  .low_ns_i  (low_ns_i),
  .high_ns_i (high_ns_i),
  .sel_ns    (sel_ns),
  .pin_o     (pin_o)
);

// File: tb/sim_ptp_pin_wavegen.sv
`timescale 1ns/1ps
module sim_ptp_pin_wavegen;
  localparam int N_DOM = 3;
  localparam int NS_W  = 30;
  localparam int STEP  = 5;
  localparam int SEC   = 1_000_000_000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] act = 2'd0;
  logic [1:0] sync = 2'd0;
  logic [1:0] sel = 2'd0;
  logic [NS_W-1:0] lo = '0;
  logic [NS_W-1:0] hi = '0;
  logic [NS_W-1:0] dns [N_DOM];
  logic            dsec [N_DOM];
  logic            ld [N_DOM];
  logic [NS_W-1:0] ldv [N_DOM];
  logic [NS_W-1:0] seen_ns [N_DOM];
  logic            seen_sec [N_DOM];
  logic [N_DOM*NS_W-1:0] dom_ns;
  logic [N_DOM-1:0]      dom_sec;
  logic pin_o;
  int n_tests = 0;
  int n_fail  = 0;
  bit rolled;

  always #2.5 clk_i = !clk_i;

  assign dom_ns  = {dns[2], dns[1], dns[0]};
  assign dom_sec = {dsec[2], dsec[1], dsec[0]};

  ptp_pin_wavegen #(.N_DOM(N_DOM), .NS_W(NS_W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .action_i(act), .sync_i(sync),
    .dom_sel_i(sel), .low_ns_i(lo), .high_ns_i(hi),
    .dom_ns_i(dom_ns), .dom_sec_i(dom_sec), .pin_o(pin_o));

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // advance one cycle: capture what the edge saw, then drive next time values
  task automatic tick();
    @(posedge clk_i);
    #1;
    for (int d = 0; d < N_DOM; d++) begin
      seen_ns[d]  = dns[d];
      seen_sec[d] = dsec[d];
      if (ld[d]) begin
        dns[d] = ldv[d]; dsec[d] = 1'b0; ld[d] = 1'b0;
      end else if (int'(dns[d]) + STEP >= SEC) begin
        dns[d] = NS_W'(int'(dns[d]) + STEP - SEC); dsec[d] = 1'b1;
      end else begin
        dns[d] = dns[d] + NS_W'(STEP); dsec[d] = 1'b0;
      end
    end
  endtask

  task automatic chk(string req, logic exp_v);
    n_tests++;
    if (pin_o !== exp_v) begin
      n_fail++;
      $display("FAIL %s: pin_o=%b expected %b at %0t", req, pin_o, exp_v, $time);
    end
  endtask

  task automatic go_idle();
    act = 2'd0;
    tick(); tick();
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin tick(); chk("R10", 1'b0); end
    rst_ni = 1'b1;
    tick(); chk("R10", 1'b0);
  endtask

  task automatic t_free(string req, int d, int l, int h, int n);
    int p, lc;
    act = 2'd1; sync = 2'd0; sel = 2'(d); lo = NS_W'(l); hi = NS_W'(h);
    p = (l + h) / STEP; lc = l / STEP;
    for (int k = 0; k < n; k++) begin
      tick();
      chk(req, (k % p) >= lc);
    end
  endtask

  task automatic t_hold_low(string req, int n);
    for (int k = 0; k < n; k++) begin tick(); chk(req, 1'b0); end
  endtask

  task automatic pps_run(string req, int d, int n);
    rolled = 1'b0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (seen_sec[d]) rolled = 1'b1;
      chk(req, rolled && seen_ns[d] >= lo && seen_ns[d] < lo + hi);
    end
  endtask

  task automatic t_idle();
    t_free("R2", 0, 20, 10, 5);   // ends in high phase
    chk("R2", 1'b1);
    act = 2'd0; tick(); chk("R1", 1'b0);
    t_hold_low("R1", 6);
    act = 2'd2; t_hold_low("R1", 6);
  endtask

  task automatic t_pps_basic();
    ld[0] = 1'b1; ldv[0] = '0; go_idle();
    act = 2'd1; sync = 2'd3; sel = 2'd0; lo = 30; hi = 20;
    pps_run("R5", 0, 14);          // passes [30,50) before any wrap
    ld[0] = 1'b1; ldv[0] = NS_W'(SEC - 50);
    pps_run("R6", 0, 30);
    ld[0] = 1'b1; ldv[0] = NS_W'(SEC - 20);
    pps_run("R6", 0, 25);          // second pulse in next second
  endtask

  task automatic t_pps_same_cycle();
    ld[0] = 1'b1; ldv[0] = NS_W'(SEC - 40); go_idle();
    act = 2'd1; sync = 2'd3; sel = 2'd0; lo = 0; hi = 20;
    pps_run("R7", 0, 16);
    ld[0] = 1'b1; ldv[0] = NS_W'(SEC - 20); hi = 0;
    pps_run("R8", 0, 12);
  endtask

  initial begin
    for (int d = 0; d < N_DOM; d++) begin
      dns[d] = NS_W'(d * 1000); dsec[d] = 1'b0; ld[d] = 1'b0; ldv[d] = '0;
      seen_ns[d] = '0; seen_sec[d] = 1'b0;
    end
    t_reset();
    t_free("R2", 0, 20, 10, 11);
    t_free("R4", 1, 15, 35, 24);   // domain change restarts
    go_idle();
    t_free("R2", 2, 10, 25, 21);
    t_idle();
    ld[0] = 1'b1; ldv[0] = NS_W'(SEC - 30); go_idle();
    t_free("R3", 0, 20, 10, 30);
    go_idle();
    act = 2'd1; sync = 2'd0; sel = 2'd0; lo = 15; hi = 0;
    t_hold_low("R8", 20);
    go_idle();
    act = 2'd1; sync = 2'd0; sel = 2'd3; lo = 10; hi = 10;
    t_hold_low("R9", 20);
    go_idle();
    t_pps_basic();
    t_pps_same_cycle();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end
endmodule